// File: doc/BRIEF.md
# Two-Dimensional Strided Address Walker

This block turns one transfer request into the stream of beat addresses for a rectangular, strided memory region. A request gives a start address, a row length in bytes, a row count, the distance in bytes between the starts of two consecutive rows, an identifier and a repeat flag. Row length and row count both arrive as the value minus one. The walker steps through each row one bus word at a time. When a row ends it jumps to the previous row's start plus the stride. When the last row is done it reports completion with the request's identifier.

When the row count is one, the walk is a plain linear run. With the repeat flag set, the walker goes back to the start address after the final row and walks the same region again, with no new request, until the channel is disabled. The beat address output always shows the address being worked on, so status logic can read the position of a running transfer. A request that breaks the alignment or length rules is taken off the request port and dropped. It issues no beats and is answered by a completion flagged as an error.

The block is used by the read and write sides of a DMA channel. Each beat address goes to the bus engine through a valid/ready pair. The bus protocol itself sits outside this block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, with `enable` high, `beat_valid` and `done` are low and `req_ready` is high.
- R2: `req_ready` is high only while `enable` is high and no transfer is running; the first beat address, equal to the start address, is presented in the cycle after a valid request is accepted.
- R3: Within a row, each accepted beat advances `beat_addr` by BB bytes (default 4), and a row of `req_xlen_m1`+1 bytes takes (`req_xlen_m1`+1)/BB beats.
- R4: The first beat of each row after the first is at the previous row's first address plus `req_stride`.
- R5: With `req_ylen_m1` = 0 the walk is one linear run of `req_xlen_m1`+1 bytes, and the stride value has no effect.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_addr` holds its value.
- R7: `done` is high for one cycle, in the cycle after the last beat of the last row is accepted, with `done_id` equal to the request's `req_id` and `done_err` low; without the repeat flag, the walker is then idle.
- R8: With `req_cyclic` high, the beat after the last beat of the last row is again at the start address, and `done` pulses at every such wrap.
- R9: A request is rejected when any of these holds: the start address has a nonzero value in its low log2(BB) bits; `req_xlen_m1`+1 is not a multiple of BB; `req_xlen_m1` is all ones (length 2^LW, above the maximum 2^LW-1); the stride is not a multiple of BB; there is more than one row and the stride is smaller than the row length; `req_ylen_m1` is all ones. A rejected request produces no beat, and in the cycle after acceptance it gives `done` and `done_err` high with `done_id` equal to its `req_id`.
- R10: When `enable` is low, `beat_valid` and `req_ready` are low at once, the walker is idle at the next clock edge, and the request in flight is dropped without a `done`.
- R11: Every presented beat address is a multiple of BB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low aborts and idles the walker |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker can take a request |
| req_addr | input | AW | Start address |
| req_xlen_m1 | input | LW | Row length in bytes, minus one |
| req_ylen_m1 | input | LW | Row count, minus one |
| req_stride | input | LW | Byte distance between row starts |
| req_cyclic | input | 1 | Repeat the region until disabled |
| req_id | input | IDW | Request identifier |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the beat address |
| beat_addr | output | AW | Current beat address, also the status position |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | IDW | Identifier of the completed request |
| done_err | output | 1 | Completion is a rejection |

## Verification
Linear single-row runs check that the byte counter ends rows at the right point, with no stride step involved. Multi-row runs with a tight stride (equal to the row length) and a wide stride show whether the row jump uses the row base or the running address. Single-beat rows and the largest legal row length test the row-end compare at both ends of its range. Random transfers, stalled by a random `beat_ready`, show that stalls freeze the address. Cyclic runs followed by a disable separate a true wrap from a fresh start. Each kind of malformed request is applied alone, so each rejection rule is tested on its own.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/dma2d_req_check.sv
module dma2d_req_check #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int BB = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] xlen_m1,
  input  logic [LW-1:0] ylen_m1,
  input  logic [LW-1:0] stride,
  output logic          ok
);
  localparam int LB = $clog2(BB);

  logic addr_ok, xlen_ok, stride_ok, fit_ok, ylen_ok;

  always_comb begin
    addr_ok   = (addr[LB-1:0] == '0);
    // length is a multiple of BB exactly when the low bits of length-1 are all ones
    xlen_ok   = (&xlen_m1[LB-1:0]) && !(&xlen_m1);
    stride_ok = (stride[LB-1:0] == '0);
    // stride >= length  <=>  stride > length-1
    fit_ok    = (ylen_m1 == '0) || ({1'b0, stride} > {1'b0, xlen_m1});
    ylen_ok   = !(&ylen_m1);
    ok        = addr_ok && xlen_ok && stride_ok && fit_ok && ylen_ok;
  end
endmodule

// File: rtl/dma2d_span_cnt.sv
module dma2d_span_cnt #(
  parameter int W    = 12,
  parameter int STEP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit_m1,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (W+1)'(STEP);
    last  = (sum > {1'b0, limit_m1});
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (adv)
      cnt_d = last ? '0 : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr || adv)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dma2d_addr_step.sv
module dma2d_addr_step #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int BB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          beat,
  input  logic          row_end,
  input  logic          xfer_end,
  input  logic [LW-1:0] stride,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] start_q, base_q, addr_q;
  logic [AW-1:0] start_d, base_d, addr_d, next_base;

  always_comb begin
    next_base = base_q + AW'(stride);
    start_d   = start_q;
    base_d    = base_q;
    addr_d    = addr_q;
    if (load) begin
      start_d = load_addr;
      base_d  = load_addr;
      addr_d  = load_addr;
    end else if (beat) begin
      if (xfer_end) begin
        base_d = start_q;
        addr_d = start_q;
      end else if (row_end) begin
        base_d = next_base;
        addr_d = next_base;
      end else begin
        addr_d = addr_q + AW'(BB);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      base_q  <= '0;
      addr_q  <= '0;
    end else if (load || beat) begin
      start_q <= start_d;
      base_q  <= base_d;
      addr_q  <= addr_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LW  = 12,
  parameter int BB  = 4,
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [LW-1:0]  req_xlen_m1,
  input  logic [LW-1:0]  req_ylen_m1,
  input  logic [LW-1:0]  req_stride,
  input  logic           req_cyclic,
  input  logic [IDW-1:0] req_id,
  output logic           beat_valid,
  input  logic           beat_ready,
  output logic [AW-1:0]  beat_addr,
  output logic           done,
  output logic [IDW-1:0] done_id,
  output logic           done_err
);
  walk_state_e    state_q, state_d;
  logic [LW-1:0]  xm1_q, ym1_q, stride_q;
  logic           cyc_q;
  logic [IDW-1:0] id_q;
  logic           done_q, done_d, err_q, err_d;
  logic           req_ok, accept, fire, x_last, y_last, row_end, xfer_end, cnt_clr;

  dma2d_req_check #(.AW(AW), .LW(LW), .BB(BB)) u_check (
    .addr    (req_addr),
    .xlen_m1 (req_xlen_m1),
    .ylen_m1 (req_ylen_m1),
    .stride  (req_stride),
    .ok      (req_ok)
  );

  always_comb begin
    req_ready  = enable && (state_q == ST_IDLE);
    beat_valid = enable && (state_q == ST_RUN);
    accept     = req_valid && req_ready;
    fire       = beat_valid && beat_ready;
    row_end    = fire && x_last;
    xfer_end   = row_end && y_last;
    cnt_clr    = accept || !enable;
  end

  dma2d_span_cnt #(.W(LW), .STEP(BB)) u_xcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .adv      (fire),
    .limit_m1 (xm1_q),
    .last     (x_last)
  );

  dma2d_span_cnt #(.W(LW), .STEP(1)) u_ycnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .adv      (row_end),
    .limit_m1 (ym1_q),
    .last     (y_last)
  );

  dma2d_addr_step #(.AW(AW), .LW(LW), .BB(BB)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (req_addr),
    .beat      (fire),
    .row_end   (row_end),
    .xfer_end  (xfer_end),
    .stride    (stride_q),
    .addr      (beat_addr)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_ok) begin
              state_d = ST_RUN;
            end else begin
              done_d = 1'b1;
              err_d  = 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (xfer_end) begin
            done_d = 1'b1;
            if (!cyc_q)
              state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // state and pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // request fields, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xm1_q    <= '0;
      ym1_q    <= '0;
      stride_q <= '0;
      cyc_q    <= 1'b0;
      id_q     <= '0;
    end else if (accept) begin
      xm1_q    <= req_xlen_m1;
      ym1_q    <= req_ylen_m1;
      stride_q <= req_stride;
      cyc_q    <= req_cyclic;
      id_q     <= req_id;
    end
  end

  assign done     = done_q;
  assign done_err = err_q;
  assign done_id  = id_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW  = 32,
  parameter int LW  = 12,
  parameter int BB  = 4,
  parameter int IDW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          req_ready,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_addr,
  input logic          done,
  input logic          done_err
);
  localparam int LB = $clog2(BB);

  // R2
  idle_or_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_valid && req_ready));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (!beat_valid || $stable(beat_addr)));

  // R11
  beat_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[LB-1:0] == '0));

  // R10
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!beat_valid && !done));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  // R7
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> $past(beat_valid && beat_ready));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .LW(LW), .BB(BB), .IDW(IDW)) u_chk (.*);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
  localparam int AW = 32, LW = 12, BB = 4, IDW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, enable, req_valid, req_ready, req_cyclic;
  logic [AW-1:0]  req_addr, beat_addr;
  logic [LW-1:0]  req_xlen_m1, req_ylen_m1, req_stride;
  logic [IDW-1:0] req_id, done_id;
  logic           beat_valid, beat_ready, done, done_err;

  int n_chk = 0, n_fail = 0;

  dma2d_addr_gen #(.AW(AW), .LW(LW), .BB(BB), .IDW(IDW)) i_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_xlen_m1(req_xlen_m1), .req_ylen_m1(req_ylen_m1), .req_stride(req_stride),
    .req_cyclic(req_cyclic), .req_id(req_id),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .done(done), .done_id(done_id), .done_err(done_err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic send(input logic [AW-1:0] a, input logic [LW-1:0] xm1,
                      input logic [LW-1:0] ym1, input logic [LW-1:0] st,
                      input bit cyc, input logic [IDW-1:0] id);
    @(negedge clk);
    req_addr = a; req_xlen_m1 = xm1; req_ylen_m1 = ym1;
    req_stride = st; req_cyclic = cyc; req_id = id; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R2", "ready when idle", req_ready, 1);
    @(posedge clk);
  endtask

  // expected beat sequence computed from the row/stride rules
  task automatic run_xfer(input logic [AW-1:0] a, input int xlen, input int rows,
                          input int stride, input bit cyc, input logic [IDW-1:0] id,
                          input int wraps);
    logic [AW-1:0] ex_addr, ex_base;
    int ex_x, ex_y, seen;
    bit pend;
    string tag;
    ex_addr = a; ex_base = a; ex_x = 0; ex_y = 0; seen = 0; pend = 0;
    tag = cyc ? "R8" : ((rows > 1) ? "R4" : "R5");
    send(a, LW'(xlen - 1), LW'(rows - 1), LW'(stride), cyc, id);
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      beat_ready = ($urandom % 4) != 0;
      #1;
      if (pend) begin
        chk(done == 1'b1, cyc ? "R8" : "R7", "done after last beat", done, 1);
        chk(done_id == id, "R7", "done id", done_id, id);
        chk(done_err == 1'b0, "R7", "no error", done_err, 0);
        pend = 0;
        seen++;
        if (!cyc) begin
          chk(beat_valid == 1'b0 && req_ready == 1'b1, "R7", "idle after done",
              {beat_valid, req_ready}, 2'b01);
          break;
        end
      end else begin
        chk(done == 1'b0, "R7", "no early done", done, 0);
      end
      if (seen >= wraps) begin
        beat_ready = 1'b0;
        break;
      end
      chk(beat_valid == 1'b1, "R3", "valid while running", beat_valid, 1);
      chk(beat_addr == ex_addr, (ex_x == 0) ? tag : "R3", "beat address", beat_addr, ex_addr);
      chk(req_ready == 1'b0, "R2", "busy not ready", req_ready, 0);
      if (beat_ready) begin
        if (ex_x + BB == xlen) begin
          ex_x = 0;
          if (ex_y == rows - 1) begin
            ex_y = 0; ex_base = a; ex_addr = a; pend = 1;
          end else begin
            ex_y++; ex_base = ex_base + AW'(stride); ex_addr = ex_base;
          end
        end else begin
          ex_x += BB; ex_addr = ex_addr + AW'(BB);
        end
      end
    end
    if (cyc) begin
      enable = 1'b0;
      #1 chk(beat_valid == 1'b0 && req_ready == 1'b0, "R10", "outputs low when disabled",
             {beat_valid, req_ready}, 0);
      @(posedge clk);
      @(negedge clk);
      #1 chk(beat_valid == 1'b0 && done == 1'b0, "R10", "quiet after disable",
             {beat_valid, done}, 0);
      enable = 1'b1;
      #1 chk(req_ready == 1'b1, "R10", "idle after disable", req_ready, 1);
    end
  endtask

  task automatic bad_req(input logic [AW-1:0] a, input logic [LW-1:0] xm1,
                         input logic [LW-1:0] ym1, input logic [LW-1:0] st);
    send(a, xm1, ym1, st, 1'b0, 4'hA);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(done == 1'b1 && done_err == 1'b1, "R9", "reject pulse", {done, done_err}, 2'b11);
    chk(done_id == 4'hA, "R9", "reject id", done_id, 4'hA);
    chk(beat_valid == 1'b0, "R9", "no beat on reject", beat_valid, 0);
    @(negedge clk);
    #1 chk(done == 1'b0 && beat_valid == 1'b0, "R9", "reject single pulse",
           {done, beat_valid}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; enable = 1'b1; req_valid = 1'b0; beat_ready = 1'b0;
    req_addr = '0; req_xlen_m1 = '0; req_ylen_m1 = '0; req_stride = '0;
    req_cyclic = 1'b0; req_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(beat_valid == 1'b0, "R1", "reset beat_valid", beat_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);

    // directed corners
    run_xfer(32'h0000_1000, 16, 1, 0, 1'b0, 4'h1, 1);        // R5 linear, stride unused
    run_xfer(32'h0000_2000, 4, 3, 4, 1'b0, 4'h2, 1);         // single-beat rows, tight stride
    run_xfer(32'h0000_3000, 12, 4, 12, 1'b0, 4'h3, 1);       // R4 stride equal to row length
    run_xfer(32'h0000_4000, 8, 3, 256, 1'b0, 4'h4, 1);       // R4 wide stride
    run_xfer(32'h0001_0000, 4092, 1, 0, 1'b0, 4'h5, 1);      // largest legal row
    run_xfer(32'h0000_5000, 8, 2, 16, 1'b1, 4'h6, 3);        // R8 cyclic, three wraps
    run_xfer(32'h0000_6000, 4, 1, 0, 1'b1, 4'h7, 2);         // R8 one-beat cyclic

    // R9 rejections, one rule each
    bad_req(32'h0000_7002, 12'd15, 12'd0, 12'd0);            // misaligned start
    bad_req(32'h0000_7000, 12'd5, 12'd0, 12'd0);             // length 6
    bad_req(32'h0000_7000, 12'hFFF, 12'd0, 12'd0);           // length 2^LW
    bad_req(32'h0000_7000, 12'd7, 12'd1, 12'd18);            // misaligned stride
    bad_req(32'h0000_7000, 12'd15, 12'd1, 12'd8);            // stride below row length
    bad_req(32'h0000_7000, 12'd7, 12'hFFF, 12'd8);           // too many rows

    // R10 abort mid-transfer
    send(32'h0000_8000, 12'd63, 12'd3, 12'd64, 1'b0, 4'h9);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      beat_ready = 1'b1;
    end
    @(negedge clk);
    enable = 1'b0;
    #1 chk(beat_valid == 1'b0 && req_ready == 1'b0, "R10", "disabled outputs",
           {beat_valid, req_ready}, 0);
    @(negedge clk);
    #1 chk(beat_valid == 1'b0 && done == 1'b0, "R10", "abort quiet", {beat_valid, done}, 0);
    enable = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1 chk(beat_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R10",
             "request dropped", {beat_valid, done, req_ready}, 3'b001);
    end

    // constrained random transfers, stalls from random beat_ready
    for (int t = 0; t < 30; t++) begin
      int xl, rw, st;
      logic [AW-1:0] a;
      xl = BB * (1 + int'($urandom % 6));
      rw = 1 + int'($urandom % 4);
      st = xl + BB * int'($urandom % 3);
      a  = {$urandom} & 32'h000F_FFFC;
      run_xfer(a, xl, rw, st, 1'b0, IDW'(t), 1);
    end

    summary();
  end
endmodule